// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a frame DMA engine. Incoming frames arrive as a byte stream. The block places them into software-supplied buffers that are listed in a ring of two-word descriptors kept in a descriptor memory. For every buffer it uses, the block first reads the descriptor's address word. It uses the buffer only when software has released it. It then writes the frame bytes to the buffer and closes the descriptor by writing its status word. The last step is to set the ownership bit, which hands the buffer to software.

A frame longer than one buffer continues into the following descriptors. Start and end markers are placed on the first and last pieces. A descriptor flagged as the ring's end sends the block back to the ring base. When the block needs a descriptor that software still owns, it discards the rest of the frame and pulses an overflow flag. The byte port stalls the sender with a ready signal while the block fetches or writes back descriptors.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `in_ready`, `ovf_pulse`, `dm_wr_en` and `buf_we` are all 0 until a frame byte is offered.
- R2: A descriptor sits at an even word index p of the descriptor memory. Its address word is at p and its status word is at p+1. In the address word, bit 0 is ownership (1 = held by software), bit 1 is the ring-end flag, and bits 31:2 are the word address of the buffer.
- R3: If the descriptor needed at the start of a frame has ownership 1, every byte of the frame is accepted and discarded. Nothing is written to the buffers or to the descriptor memory, and `ovf_pulse` is high for exactly one cycle.
- R4: Each accepted byte is written once to byte address 4*(buffer word address) + offset, with offsets 0, 1, 2, ... in arrival order.
- R5: The status word written back holds the length in bits 13:0, SOF in bit 14 and EOF in bit 15, with bits 31:16 zero. On the final descriptor of a frame the length is the total frame length. On every other descriptor it is `BUF_BYTES`.
- R6: A frame longer than `BUF_BYTES` fills buffers in ring order. SOF is set only on its first descriptor and EOF only on its last. A frame of exactly `BUF_BYTES` bytes uses one descriptor with both flags set.
- R7: The address word, with ownership set to 1 and its other bits unchanged, is written in the cycle right after the same descriptor's status word.
- R8: After a descriptor with the ring-end flag set, the next descriptor used is at `ring_base`. Otherwise it is at p+2.
- R9: If the descriptor needed to continue a frame has ownership 1, the rest of the frame is discarded, `ovf_pulse` is high for one cycle, and the buffers already filled keep their write-back. The next frame starts at that same descriptor.
- R10: `ring_base` (even) is taken as the first descriptor position when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | DM_AW | Word index of the first descriptor (even) |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the final one of its frame |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| dm_addr | output | DM_AW | Descriptor memory word address |
| dm_rd_en | output | 1 | Descriptor read; data is returned on the next cycle |
| dm_rdata | input | 32 | Descriptor read data |
| dm_wr_en | output | 1 | Descriptor word write |
| dm_wdata | output | 32 | Descriptor write data |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_data | output | 8 | Buffer byte data |
| ovf_pulse | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
Two events can fall on the same byte: the buffer filling up and the frame ending. When they coincide, the block must close the descriptor with EOF set and must not fetch another one. The bench provokes this with frames whose length is exactly one or two buffers, and also with random lengths around those sizes. It then compares every descriptor word and buffer byte against a ring model computed in the bench. Running out of descriptors in the middle of a frame is a second collision, between the spanning logic and the overflow path. It is judged by the overflow count and by the descriptor that the next frame lands in.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int OWN_BIT  = 0;
    localparam int WRAP_BIT = 1;
    localparam int LEN_W    = 14;

    typedef enum logic [2:0] {
        S_INIT,
        S_IDLE,
        S_FETCH,
        S_CHECK,
        S_DATA,
        S_WSTAT,
        S_WADDR,
        S_DROP
    } rxr_state_e;
endpackage

// File: rtl/rxr_ring_step.sv
module rxr_ring_step #(
    parameter int DM_AW = 8
) (
    input  logic [DM_AW-1:0] cur,
    input  logic [DM_AW-1:0] base,
    input  logic             wrap,
    output logic [DM_AW-1:0] nxt
);
    always_comb begin
        nxt = wrap ? base : cur + DM_AW'(2);
    end
endmodule

// File: rtl/rxr_status_fmt.sv
module rxr_status_fmt #(
    parameter int BUF_BYTES = 16
) (
    input  logic                      sof,
    input  logic                      eof,
    input  logic [rxr_pkg::LEN_W-1:0] flen,
    input  logic [31:0]               desc,
    output logic [31:0]               status,
    output logic [31:0]               own_word
);
    localparam logic [rxr_pkg::LEN_W-1:0] FULL_LEN = rxr_pkg::LEN_W'(BUF_BYTES);

    always_comb begin
        status   = {16'h0, eof, sof, (eof ? flen : FULL_LEN)};
        own_word = desc | 32'h1;
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
    parameter int DM_AW     = 8,
    parameter int BUF_BYTES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DM_AW-1:0] ring_base,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic [DM_AW-1:0] dm_addr,
    output logic             dm_rd_en,
    input  logic [31:0]      dm_rdata,
    output logic             dm_wr_en,
    output logic [31:0]      dm_wdata,
    output logic             buf_we,
    output logic [31:0]      buf_addr,
    output logic [7:0]       buf_data,
    output logic             ovf_pulse
);
    import rxr_pkg::*;

    localparam int OFF_W = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(BUF_BYTES - 1);

    typedef struct packed {
        rxr_state_e       state;
        logic [DM_AW-1:0] ptr;
        logic [31:0]      desc;
        logic [OFF_W-1:0] off;
        logic [LEN_W-1:0] flen;
        logic             sof;
        logic             eof;
        logic             ovf;
    } regs_t;

    regs_t r_q, r_d;

    logic [DM_AW-1:0] next_ptr_d;
    logic [31:0]      status_d;
    logic [31:0]      own_word_d;

    rxr_ring_step #(.DM_AW(DM_AW)) u_step (
        .cur  (r_q.ptr),
        .base (ring_base),
        .wrap (r_q.desc[WRAP_BIT]),
        .nxt  (next_ptr_d)
    );

    rxr_status_fmt #(.BUF_BYTES(BUF_BYTES)) u_fmt (
        .sof      (r_q.sof),
        .eof      (r_q.eof),
        .flen     (r_q.flen),
        .desc     (r_q.desc),
        .status   (status_d),
        .own_word (own_word_d)
    );

    always_comb begin
        r_d      = r_q;
        r_d.ovf  = 1'b0;
        in_ready = 1'b0;
        dm_addr  = r_q.ptr;
        dm_rd_en = 1'b0;
        dm_wr_en = 1'b0;
        dm_wdata = '0;
        buf_we   = 1'b0;
        buf_addr = {r_q.desc[31:2], 2'b00} + 32'(r_q.off);
        buf_data = in_data;

        case (r_q.state)
            S_INIT: begin
                r_d.ptr   = ring_base;
                r_d.state = S_IDLE;
            end
            S_IDLE: begin
                if (in_valid) begin
                    r_d.sof   = 1'b1;
                    r_d.flen  = '0;
                    r_d.state = S_FETCH;
                end
            end
            S_FETCH: begin
                dm_rd_en  = 1'b1;
                r_d.state = S_CHECK;
            end
            S_CHECK: begin
                r_d.desc = dm_rdata;
                r_d.off  = '0;
                if (dm_rdata[OWN_BIT]) begin
                    r_d.ovf   = 1'b1;
                    r_d.state = S_DROP;
                end else begin
                    r_d.state = S_DATA;
                end
            end
            S_DATA: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    buf_we   = 1'b1;
                    r_d.off  = r_q.off + OFF_W'(1);
                    r_d.flen = r_q.flen + LEN_W'(1);
                    if (in_last) begin
                        r_d.eof   = 1'b1;
                        r_d.state = S_WSTAT;
                    end else if (r_q.off == OFF_LAST) begin
                        r_d.eof   = 1'b0;
                        r_d.state = S_WSTAT;
                    end
                end
            end
            S_WSTAT: begin
                dm_wr_en  = 1'b1;
                dm_addr   = r_q.ptr + DM_AW'(1);
                dm_wdata  = status_d;
                r_d.state = S_WADDR;
            end
            S_WADDR: begin
                dm_wr_en  = 1'b1;
                dm_wdata  = own_word_d;
                r_d.ptr   = next_ptr_d;
                r_d.sof   = 1'b0;
                r_d.state = r_q.eof ? S_IDLE : S_FETCH;
            end
            S_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_last) begin
                    r_d.state = S_IDLE;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    assign ovf_pulse = r_q.ovf;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
    parameter int DM_AW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [DM_AW-1:0] dm_addr,
    input logic             dm_rd_en,
    input logic             dm_wr_en,
    input logic [31:0]      dm_wdata,
    input logic             buf_we,
    input logic             ovf_pulse
);
    // R7: ownership word follows the status word of the same descriptor
    assert_owner_after_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_wr_en && !dm_addr[0]) |->
            ($past(dm_wr_en) && $past(dm_addr) == dm_addr + DM_AW'(1) && dm_wdata[0]));

    // R4: buffer bytes are written only for accepted stream bytes
    assert_buf_write_accepted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (in_valid && in_ready));

    // R3: overflow is a single-cycle pulse
    assert_ovf_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse);

    // R3: a dropped frame causes no write
    assert_ovf_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (!buf_we && !dm_wr_en));

    // R2: descriptor reads never overlap writes or byte acceptance
    assert_read_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dm_rd_en |-> (!dm_wr_en && !in_ready && !buf_we));

    // R5: status word has zero upper half and nonzero length
    assert_status_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_wr_en && dm_addr[0]) |->
            ((dm_wdata & 32'hFFFF_0000) == 32'h0 && (dm_wdata & 32'h0000_3FFF) != 32'h0));
endmodule

bind rx_ring_writer rxr_checker #(.DM_AW(DM_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .dm_addr   (dm_addr),
    .dm_rd_en  (dm_rd_en),
    .dm_wr_en  (dm_wr_en),
    .dm_wdata  (dm_wdata),
    .buf_we    (buf_we),
    .ovf_pulse (ovf_pulse)
);

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;
    localparam int DM_AW   = 8;
    localparam int BUF     = 16;
    localparam int NDESC   = 6;
    localparam int BASE    = 8;
    localparam int BUFBASE = 1024;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [DM_AW-1:0] ring_base;
    logic             in_valid;
    logic [7:0]       in_data;
    logic             in_last;
    logic             in_ready;
    logic [DM_AW-1:0] dm_addr;
    logic             dm_rd_en;
    logic [31:0]      dm_rdata;
    logic             dm_wr_en;
    logic [31:0]      dm_wdata;
    logic             buf_we;
    logic [31:0]      buf_addr;
    logic [7:0]       buf_data;
    logic             ovf_pulse;

    always #10 clk = ~clk;

    rx_ring_writer #(.DM_AW(DM_AW), .BUF_BYTES(BUF)) i_rx_ring_writer (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .dm_addr(dm_addr), .dm_rd_en(dm_rd_en), .dm_rdata(dm_rdata),
        .dm_wr_en(dm_wr_en), .dm_wdata(dm_wdata),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data), .ovf_pulse(ovf_pulse)
    );

    logic [31:0] dmem   [256];
    logic [31:0] exp_dm [256];
    logic [7:0]  bm     [2048];
    logic [7:0]  exp_bm [2048];
    logic [7:0]  fbytes [64];

    int vectors = 0;
    int errors = 0;
    int ovf_seen = 0;
    int ovf_exp = 0;
    int dm_writes = 0;
    int exp_ptr = BASE;
    logic             prev_wr = 1'b0;
    logic [DM_AW-1:0] prev_addr = '0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory models and monitors
    always @(posedge clk) begin
        if (dm_rd_en) dm_rdata <= dmem[dm_addr];
        if (dm_wr_en) begin
            dmem[dm_addr] <= dm_wdata;
            dm_writes++;
        end
        if (buf_we) bm[buf_addr[10:0]] <= buf_data;
        if (ovf_pulse) ovf_seen++;
        if (rst_n && dm_wr_en && !dm_addr[0]) begin
            // R7: status write of same descriptor in the previous cycle, owner bit set
            chk("R7 owner-last order", {31'h0, (prev_wr && prev_addr == DM_AW'(dm_addr + DM_AW'(1)) && dm_wdata[0])}, 32'h1);
        end
        prev_wr   <= dm_wr_en;
        prev_addr <= dm_addr;
    end

    task automatic model_frame(int len);
        int p = exp_ptr;
        int i = 0;
        int chunk;
        bit first = 1'b1;
        bit last;
        logic [31:0] d;
        while (i < len) begin
            d = exp_dm[p];
            if (d[0]) begin
                ovf_exp++;
                break;
            end
            chunk = (len - i > BUF) ? BUF : len - i;
            for (int k = 0; k < chunk; k++) exp_bm[int'(d[31:2]) * 4 + k] = fbytes[i + k];
            last = (i + chunk == len);
            exp_dm[p + 1] = {16'h0, last, first, (last ? 14'(len) : 14'(BUF))};
            exp_dm[p] = d | 32'h1;
            p = d[1] ? BASE : p + 2;
            first = 1'b0;
            i += chunk;
        end
        exp_ptr = p;
    endtask

    task automatic drive_frame(int len, int gapmax);
        int i = 0;
        bit acc;
        for (int k = 0; k < len; k++) fbytes[k] = 8'($urandom);
        model_frame(len);
        while (i < len) begin
            @(negedge clk);
            if (gapmax > 0 && $urandom_range(0, gapmax) == 0) begin
                in_valid = 1'b0;
                in_last  = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_data  = fbytes[i];
                in_last  = (i == len - 1);
            end
            acc = in_valid && in_ready;
            @(posedge clk);
            if (acc) i++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic compare_all(string req);
        for (int p = BASE; p < BASE + 2 * NDESC; p++) chk({req, " descriptor word"}, dmem[p], exp_dm[p]);
        for (int a = BUFBASE; a < BUFBASE + NDESC * BUF; a++) chk({req, " buffer byte"}, 32'(bm[a]), 32'(exp_bm[a]));
        chk({req, " R3 overflow count"}, ovf_seen, ovf_exp);
    endtask

    task automatic give_back(int idx);
        int p = BASE + 2 * idx;
        dmem[p]       = dmem[p] & ~32'h1;
        dmem[p + 1]   = 32'hF000_0000;
        exp_dm[p]     = exp_dm[p] & ~32'h1;
        exp_dm[p + 1] = 32'hF000_0000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) begin dmem[a] = '0; exp_dm[a] = '0; end
        for (int a = 0; a < 2048; a++) begin bm[a] = '0; exp_bm[a] = '0; end
        for (int n = 0; n < NDESC; n++) begin
            dmem[BASE + 2 * n]     = 32'(BUFBASE + n * BUF) | ((n == NDESC - 1) ? 32'h2 : 32'h0);
            dmem[BASE + 2 * n + 1] = 32'hF000_0000;
            exp_dm[BASE + 2 * n]     = dmem[BASE + 2 * n];
            exp_dm[BASE + 2 * n + 1] = 32'hF000_0000;
        end
        void'($urandom(32'h5EED_1234));
        dm_rdata  = '0;
        ring_base = DM_AW'(BASE);
        in_valid  = 1'b0;
        in_data   = '0;
        in_last   = 1'b0;
        rst_n     = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk("R1 in_ready after reset", 32'(in_ready), 32'h0);
        chk("R1 ovf_pulse after reset", 32'(ovf_pulse), 32'h0);
        chk("R1 no descriptor writes", dm_writes, 0);
        chk("R1 no buffer write", 32'(buf_we), 32'h0);

        // R2 R4 R10: short frame lands in first descriptor at ring_base
        drive_frame(5, 0);
        compare_all("R2 R4 R10 short frame");
        // R5 R6: exactly one buffer, SOF and EOF together
        drive_frame(BUF, 0);
        compare_all("R5 R6 exact-buffer frame");
        // R6: spanning three buffers
        drive_frame(40, 0);
        compare_all("R6 spanning frame");
        // R8: ring-end descriptor then wrap to base, base still owned -> R3 drop
        drive_frame(10, 1);
        compare_all("R8 ring-end descriptor");
        drive_frame(7, 0);
        compare_all("R3 owned at frame start");
        // R9: two free descriptors, frame needs three
        give_back(0);
        give_back(1);
        drive_frame(40, 0);
        compare_all("R9 owned mid-frame");
        // R9: next frame retries the descriptor that stopped the previous one
        for (int n = 0; n < NDESC; n++) give_back(n);
        drive_frame(3, 0);
        compare_all("R9 retry descriptor");
        // R6: two full buffers exactly
        drive_frame(2 * BUF, 0);
        compare_all("R6 double exact frame");

        // random mix
        for (int f = 0; f < 30; f++) begin
            for (int n = 0; n < NDESC; n++)
                if ($urandom_range(0, 2) != 0) give_back(n);
            drive_frame($urandom_range(1, 45), 2);
            compare_all("R4 R5 R6 R8 random frame");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule